// File: doc/BRIEF.md
# Variable Block Size SAD Merger

This block sits behind a bank of sixteen 4x4 block-matching units. For each candidate search position of a 16x16 macroblock, it takes the sixteen 4x4 sum-of-absolute-difference (SAD) values for that position together with the candidate's motion vector. An adder chain builds the SAD of every larger partition from those values: 8x4, 4x8, 8x8, 16x8, 8x16 and 16x16. The block then compares each of the 41 partition SADs with the minimum held for that partition, and each partition keeps its own best SAD and the motion vector that produced it.

One candidate can be accepted on every clock. A marker on the first candidate opens a new search, and a marker on the final candidate makes the block raise a one-cycle completion pulse once that candidate has passed through the pipeline. The per-partition results are then ready for the mode decision logic that follows.

Top module: `vbs_sad_merge`

## Requirements
- R1: After a synchronous active-low reset, every partition's best SAD equals the all-ones value of its own width, every best motion vector is zero, and `search_done` is low. The widths are 12 bits for 4x4, 13 for 8x4 and 4x8, 14 for 8x8, 15 for 16x8 and 8x16, and 16 for 16x16. Each result sits zero-extended in its 16-bit slot.
- R2: Input SAD slot i (bits i*12 and up) belongs to 4x4 block i, counted in raster order (row = i/4, column = i%4). Result slots 0..15 hold the minima for these blocks in the same order.
- R3: Result slots 16..23 hold the 8x4 partitions, with slot 16+j covering row j/2 and columns 2*(j%2) and 2*(j%2)+1. Result slots 24..31 hold the 4x8 partitions, with slot 24+j covering rows 2*(j/4) and 2*(j/4)+1 in column j%4.
- R4: Result slots 32..35 hold the 8x8 quadrants, with slot 32+q covering rows 2*(q/2) and 2*(q/2)+1 and columns 2*(q%2) and 2*(q%2)+1.
- R5: Result slots 36..37 hold the 16x8 halves (slot 36+v covers rows 2v and 2v+1). Slots 38..39 hold the 8x16 halves (slot 38+h covers columns 2h and 2h+1). Slot 40 holds the whole 16x16 block.
- R6: The 16x16 sum never wraps. Sixteen inputs of 0xFFF give 0xFFF0.
- R7: A candidate replaces a stored minimum only when its SAD is strictly smaller. On a tie, the earlier candidate and its motion vector are kept.
- R8: A candidate marked as the start of a search is loaded into every partition regardless of the stored values. A start marker without a valid candidate sets every minimum back to all-ones and every motion vector to zero.
- R9: `search_done` is high for exactly one cycle, three clock edges after the edge that samples a valid candidate marked as the last one. In that cycle the results already include that candidate.
- R10: A candidate sampled at one edge changes the results after the third edge from that one and not sooner. Candidates presented on consecutive cycles are all taken in.
- R11: While `cand_valid` and `search_start` are both low, the SAD and motion vector inputs have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid | input | 1 | Candidate present this cycle |
| search_start | input | 1 | First candidate of a search (or a bare clear when not valid) |
| search_last | input | 1 | Final candidate of a search |
| cand_sad4 | input | 16*SAD4_W | Sixteen 4x4 SADs, block i at bits i*SAD4_W |
| cand_mv | input | MV_W | Motion vector of the candidate |
| best_sad | output | 41*(SAD4_W+4) | Best SAD per partition, slot p at bits p*(SAD4_W+4) |
| best_mv | output | 41*MV_W | Best motion vector per partition |
| search_done | output | 1 | One-cycle pulse once the last candidate is merged |

## Verification
The bench builds the block with its default parameters: 12-bit 4x4 SADs and a 16-bit motion vector. At these widths an all-0xFFF candidate reaches the 16x16 ceiling exactly, so the check on the widest adder and the check on the all-ones initial values both fall at real limits. Sixteen-bit vectors are wide enough that every candidate in a search carries a distinct tag. Because of that, a wrong tie rule or a wrong partition mapping appears in the motion vectors as well as in the SADs.

// File: rtl/vbs_pkg.sv
// Shared constants for the variable block size SAD merger.
// Assumes a 16x16 macroblock split into a 4x4 grid of 4x4 blocks.
package vbs_pkg;
    localparam int NBLK  = 16;  // 4x4 blocks per macroblock
    localparam int NPART = 41;  // tracked partitions of all sizes
    localparam int N_1   = 8;   // 8x4 (and 4x8) partitions
    localparam int N_2   = 4;   // 8x8 partitions
    localparam int N_3   = 2;   // 16x8 (and 8x16) partitions
endpackage

// File: rtl/sad_pair_add.sv
// Widening two-input adder used at every level of the SAD chain.
// Assumes unsigned operands; the result carries one extra bit so it cannot wrap.
module sad_pair_add #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   y
);
    // Sum with carry kept as the top bit.
    always_comb y = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/sad_min_track.sv
// Running minimum of one partition SAD plus the motion vector that gave it.
// Assumes init and upd arrive aligned with cand; ties keep the stored entry.
module sad_min_track #(
    parameter int W    = 12,
    parameter int MV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic            init,
    input  logic [W-1:0]    cand,
    input  logic [MV_W-1:0] cand_mv,
    output logic [W-1:0]    best,
    output logic [MV_W-1:0] best_mv
);
    // Reset, search start, or strict-less replacement of the stored minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best    <= '1;
            best_mv <= '0;
        end else if (init && upd) begin
            best    <= cand;
            best_mv <= cand_mv;
        end else if (init) begin
            best    <= '1;
            best_mv <= '0;
        end else if (upd && (cand < best)) begin
            best    <= cand;
            best_mv <= cand_mv;
        end
    end

    p_never_rises_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !init |=> best <= $past(best));
    p_tie_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !init && cand >= best) |=> ($stable(best) && $stable(best_mv)));
    p_smaller_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !init && cand < best) |=> (best == $past(cand) && best_mv == $past(cand_mv)));
    p_idle_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !init) |=> ($stable(best) && $stable(best_mv)));
endmodule

// File: rtl/vbs_sad_merge.sv
// Variable block size SAD merger: sums sixteen 4x4 SADs into all 41
// partition SADs and tracks a minimum and motion vector per partition.
// Pipeline: edge 1 registers the 8x4/4x8 sums, edge 2 registers the 8x8 and
// larger sums, edge 3 updates the minima. Control flags travel with the data.
module vbs_sad_merge
    import vbs_pkg::*;
#(
    parameter int SAD4_W = 12,
    parameter int MV_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cand_valid,
    input  logic                      search_start,
    input  logic                      search_last,
    input  logic [NBLK*SAD4_W-1:0]    cand_sad4,
    input  logic [MV_W-1:0]           cand_mv,
    output logic [NPART*(SAD4_W+4)-1:0] best_sad,
    output logic [NPART*MV_W-1:0]     best_mv,
    output logic                      search_done
);
    localparam int W1    = SAD4_W + 1;
    localparam int W2    = SAD4_W + 2;
    localparam int W3    = SAD4_W + 3;
    localparam int OUT_W = SAD4_W + 4;

    logic [SAD4_W-1:0] in4 [NBLK];
    logic [W1-1:0] l1h [N_1];
    logic [W1-1:0] l1v [N_1];

    // Stage A registers
    logic              a_vld, a_start, a_last;
    logic [MV_W-1:0]   a_mv;
    logic [SAD4_W-1:0] a_s0 [NBLK];
    logic [W1-1:0]     a_s1h [N_1];
    logic [W1-1:0]     a_s1v [N_1];

    logic [W2-1:0]     l2 [N_2];
    logic [W3-1:0]     l3h [N_3];
    logic [W3-1:0]     l3v [N_3];
    logic [OUT_W-1:0]  l4;

    // Stage B registers
    logic              b_vld, b_start, b_last;
    logic [MV_W-1:0]   b_mv;
    logic [SAD4_W-1:0] b_s0 [NBLK];
    logic [W1-1:0]     b_s1h [N_1];
    logic [W1-1:0]     b_s1v [N_1];
    logic [W2-1:0]     b_s2 [N_2];
    logic [W3-1:0]     b_s3h [N_3];
    logic [W3-1:0]     b_s3v [N_3];
    logic [OUT_W-1:0]  b_s4;

    // Level 1: horizontal (8x4) and vertical (4x8) pairs of 4x4 blocks.
    for (genvar i = 0; i < NBLK; i++) begin : g_unpack
        assign in4[i] = cand_sad4[i*SAD4_W +: SAD4_W];
    end
    for (genvar j = 0; j < N_1; j++) begin : g_l1
        sad_pair_add #(.W(SAD4_W)) u_h (
            .a(in4[(j/2)*4 + (j%2)*2]), .b(in4[(j/2)*4 + (j%2)*2 + 1]), .y(l1h[j]));
        sad_pair_add #(.W(SAD4_W)) u_v (
            .a(in4[(j/4)*8 + (j%4)]), .b(in4[(j/4)*8 + 4 + (j%4)]), .y(l1v[j]));
    end

    // Stage A control flags, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_vld <= 1'b0; a_start <= 1'b0; a_last <= 1'b0;
        end else begin
            a_vld <= cand_valid; a_start <= search_start; a_last <= search_last;
        end
    end

    // Stage A data capture.
    always_ff @(posedge clk) begin
        a_mv  <= cand_mv;
        a_s0  <= in4;
        a_s1h <= l1h;
        a_s1v <= l1v;
    end

    // Levels 2 to 4: 8x8 from 8x4 pairs, 16x8/8x16 from 8x8 pairs, 16x16.
    for (genvar q = 0; q < N_2; q++) begin : g_l2
        sad_pair_add #(.W(W1)) u_q (
            .a(a_s1h[(q/2)*4 + (q%2)]), .b(a_s1h[(q/2)*4 + 2 + (q%2)]), .y(l2[q]));
    end
    for (genvar k = 0; k < N_3; k++) begin : g_l3
        sad_pair_add #(.W(W2)) u_h (.a(l2[2*k]), .b(l2[2*k + 1]), .y(l3h[k]));
        sad_pair_add #(.W(W2)) u_v (.a(l2[k]),   .b(l2[k + 2]),   .y(l3v[k]));
    end
    sad_pair_add #(.W(W3)) u_l4 (.a(l3h[0]), .b(l3h[1]), .y(l4));

    // Stage B control flags, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_vld <= 1'b0; b_start <= 1'b0; b_last <= 1'b0;
        end else begin
            b_vld <= a_vld; b_start <= a_start; b_last <= a_last;
        end
    end

    // Stage B data capture.
    always_ff @(posedge clk) begin
        b_mv  <= a_mv;
        b_s0  <= a_s0;
        b_s1h <= a_s1h;
        b_s1v <= a_s1v;
        b_s2  <= l2;
        b_s3h <= l3h;
        b_s3v <= l3v;
        b_s4  <= l4;
    end

    // Stage C: one minimum tracker per partition, grouped by size.
    for (genvar g = 0; g < NBLK; g++) begin : g_t0
        logic [SAD4_W-1:0] tb;
        sad_min_track #(.W(SAD4_W), .MV_W(MV_W)) u_t (
            .clk(clk), .rst_n(rst_n), .upd(b_vld), .init(b_start),
            .cand(b_s0[g]), .cand_mv(b_mv), .best(tb), .best_mv(best_mv[g*MV_W +: MV_W]));
        assign best_sad[g*OUT_W +: OUT_W] = OUT_W'(tb);
    end
    for (genvar g = 0; g < N_1; g++) begin : g_t1
        logic [W1-1:0] th, tv;
        sad_min_track #(.W(W1), .MV_W(MV_W)) u_h (
            .clk(clk), .rst_n(rst_n), .upd(b_vld), .init(b_start),
            .cand(b_s1h[g]), .cand_mv(b_mv), .best(th), .best_mv(best_mv[(16+g)*MV_W +: MV_W]));
        sad_min_track #(.W(W1), .MV_W(MV_W)) u_v (
            .clk(clk), .rst_n(rst_n), .upd(b_vld), .init(b_start),
            .cand(b_s1v[g]), .cand_mv(b_mv), .best(tv), .best_mv(best_mv[(24+g)*MV_W +: MV_W]));
        assign best_sad[(16+g)*OUT_W +: OUT_W] = OUT_W'(th);
        assign best_sad[(24+g)*OUT_W +: OUT_W] = OUT_W'(tv);
    end
    for (genvar g = 0; g < N_2; g++) begin : g_t2
        logic [W2-1:0] tq;
        sad_min_track #(.W(W2), .MV_W(MV_W)) u_q (
            .clk(clk), .rst_n(rst_n), .upd(b_vld), .init(b_start),
            .cand(b_s2[g]), .cand_mv(b_mv), .best(tq), .best_mv(best_mv[(32+g)*MV_W +: MV_W]));
        assign best_sad[(32+g)*OUT_W +: OUT_W] = OUT_W'(tq);
    end
    for (genvar g = 0; g < N_3; g++) begin : g_t3
        logic [W3-1:0] th, tv;
        sad_min_track #(.W(W3), .MV_W(MV_W)) u_h (
            .clk(clk), .rst_n(rst_n), .upd(b_vld), .init(b_start),
            .cand(b_s3h[g]), .cand_mv(b_mv), .best(th), .best_mv(best_mv[(36+g)*MV_W +: MV_W]));
        sad_min_track #(.W(W3), .MV_W(MV_W)) u_v (
            .clk(clk), .rst_n(rst_n), .upd(b_vld), .init(b_start),
            .cand(b_s3v[g]), .cand_mv(b_mv), .best(tv), .best_mv(best_mv[(38+g)*MV_W +: MV_W]));
        assign best_sad[(36+g)*OUT_W +: OUT_W] = OUT_W'(th);
        assign best_sad[(38+g)*OUT_W +: OUT_W] = OUT_W'(tv);
    end
    sad_min_track #(.W(OUT_W), .MV_W(MV_W)) u_t4 (
        .clk(clk), .rst_n(rst_n), .upd(b_vld), .init(b_start),
        .cand(b_s4), .cand_mv(b_mv), .best(best_sad[40*OUT_W +: OUT_W]),
        .best_mv(best_mv[40*MV_W +: MV_W]));

    // Completion pulse aligned with the last candidate's merged results.
    always_ff @(posedge clk) begin
        if (!rst_n) search_done <= 1'b0;
        else        search_done <= b_vld && b_last;
    end

    p_done_follows_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        search_done |-> $past(cand_valid && search_last, 3));
endmodule

// File: tb/sim_vbs_sad_merge.sv
// Self-checking bench for vbs_sad_merge: a table-driven candidate walk
// against a behavioural partition model, then directed corner tests.
module sim_vbs_sad_merge;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 12;
    localparam int MW = 16;
    localparam int OW = SW + 4;

    // Entry: start, last, base, step, mv. The 4x4 SAD of block i is (base ^ (i*step)) & 0xFFF.
    localparam logic [41:0] TBL [12] = '{
        {1'b1, 1'b0, 12'd700,  12'd37,  16'h0101},
        {1'b0, 1'b0, 12'd650,  12'd91,  16'h0102},
        {1'b0, 1'b0, 12'd650,  12'd91,  16'h0103},
        {1'b0, 1'b0, 12'd900,  12'd5,   16'h0104},
        {1'b0, 1'b0, 12'd120,  12'd255, 16'h0105},
        {1'b0, 1'b1, 12'd640,  12'd13,  16'h0106},
        {1'b1, 1'b0, 12'd4000, 12'd3,   16'h0201},
        {1'b0, 1'b0, 12'd33,   12'd401, 16'h0202},
        {1'b0, 1'b0, 12'd2048, 12'd64,  16'h0203},
        {1'b0, 1'b0, 12'd17,   12'd17,  16'h0204},
        {1'b0, 1'b0, 12'd33,   12'd401, 16'h0205},
        {1'b0, 1'b1, 12'd1500, 12'd77,  16'h0206}
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cand_valid, search_start, search_last;
    logic [16*SW-1:0]   cand_sad4;
    logic [MW-1:0]      cand_mv;
    logic [41*OW-1:0]   best_sad;
    logic [41*MW-1:0]   best_mv;
    logic               search_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int mdl_best [41];
    int mdl_mv [41];
    int sv [16];

    vbs_sad_merge #(.SAD4_W(SW), .MV_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .search_start(search_start),
        .search_last(search_last), .cand_sad4(cand_sad4), .cand_mv(cand_mv),
        .best_sad(best_sad), .best_mv(best_mv), .search_done(search_done));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int all_ones(int p);
        int w;
        w = (p < 16) ? 12 : (p < 32) ? 13 : (p < 36) ? 14 : (p < 40) ? 15 : 16;
        return (1 << w) - 1;
    endfunction

    // Sum of the 4x4 blocks covered by partition p, from its rectangle.
    function automatic int part_sum(int p);
        int r0, c0, h, w, j, s;
        if (p < 16)      begin r0 = p/4; c0 = p%4; h = 1; w = 1; end
        else if (p < 24) begin j = p-16; r0 = j/2; c0 = (j%2)*2; h = 1; w = 2; end
        else if (p < 32) begin j = p-24; r0 = (j/4)*2; c0 = j%4; h = 2; w = 1; end
        else if (p < 36) begin j = p-32; r0 = (j/2)*2; c0 = (j%2)*2; h = 2; w = 2; end
        else if (p < 38) begin j = p-36; r0 = j*2; c0 = 0; h = 2; w = 4; end
        else if (p < 40) begin j = p-38; r0 = 0; c0 = j*2; h = 4; w = 2; end
        else             begin r0 = 0; c0 = 0; h = 4; w = 4; end
        s = 0;
        for (int r = r0; r < r0 + h; r++)
            for (int c = c0; c < c0 + w; c++)
                s += sv[r*4 + c];
        return s;
    endfunction

    // Drive one cycle of inputs, update the model, advance to the next falling edge.
    task automatic put(bit v, bit s, bit l, int base, int step, int mv);
        for (int i = 0; i < 16; i++) begin
            sv[i] = (base ^ (i*step)) & 12'hFFF;
            cand_sad4[i*SW +: SW] = SW'(sv[i]);
        end
        cand_valid = v; search_start = s; search_last = l; cand_mv = MW'(mv);
        for (int p = 0; p < 41; p++) begin
            if (s && v) begin mdl_best[p] = part_sum(p); mdl_mv[p] = mv; end
            else if (s) begin mdl_best[p] = all_ones(p); mdl_mv[p] = 0; end
            else if (v && part_sum(p) < mdl_best[p]) begin
                mdl_best[p] = part_sum(p); mdl_mv[p] = mv;
            end
        end
        @(negedge clk);
    endtask

    task automatic check_slots(string ctx);
        string tag;
        for (int p = 0; p < 41; p++) begin
            tag = (p < 16) ? "R2" : (p < 32) ? "R3" : (p < 36) ? "R4" : "R5";
            chk($sformatf("%s %s sad slot %0d", tag, ctx, p), int'(best_sad[p*OW +: OW]), mdl_best[p]);
            chk($sformatf("%s %s mv slot %0d", tag, ctx, p), int'(best_mv[p*MW +: MW]), mdl_mv[p]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hold;
        rst_n = 1'b0; cand_valid = 0; search_start = 0; search_last = 0;
        cand_sad4 = '0; cand_mv = '0;
        for (int p = 0; p < 41; p++) begin mdl_best[p] = all_ones(p); mdl_mv[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int p = 0; p < 41; p++) begin
            chk($sformatf("R1 reset sad slot %0d", p), int'(best_sad[p*OW +: OW]), all_ones(p));
            chk($sformatf("R1 reset mv slot %0d", p), int'(best_mv[p*MW +: MW]), 0);
        end
        chk("R1 done low", int'(search_done), 0);

        // Table walk: back-to-back candidates (R10), tie entries (R7), done (R9).
        for (int k = 0; k < 12; k++) begin
            put(1, TBL[k][41], TBL[k][40], int'(TBL[k][39:28]), int'(TBL[k][27:16]), int'(TBL[k][15:0]));
            if (TBL[k][40]) begin
                put(0, 0, 0, 12'hABC, 12'd7, 16'hDEAD);   // R11: ignored garbage
                chk("R9 done before", int'(search_done), 0);
                @(negedge clk);
                chk("R9 done high", int'(search_done), 1);
                check_slots("table");
                @(negedge clk);
                chk("R9 done one cycle", int'(search_done), 0);
            end
        end

        // R11: invalid cycles with garbage leave every result unchanged.
        put(0, 0, 0, 1, 1, 16'h7777);
        put(0, 0, 1, 2, 3, 16'h8888);
        repeat (3) @(negedge clk);
        check_slots("R11 idle");
        chk("R11 no done without valid", int'(search_done), 0);

        // R8: start without valid clears to all-ones.
        put(0, 1, 0, 5, 5, 16'h1234);
        repeat (2) @(negedge clk);
        for (int p = 0; p < 41; p++)
            chk($sformatf("R8 clear slot %0d", p), int'(best_sad[p*OW +: OW]), all_ones(p));
        chk("R8 clear mv", int'(best_mv[40*MW +: MW]), 0);

        // R6 and R10: full-scale candidate, latency of exactly three edges.
        put(1, 1, 1, 12'hFFF, 0, 16'h4242);
        hold = int'(best_sad[40*OW +: OW]);
        @(negedge clk);
        chk("R10 no change after two edges", int'(best_sad[40*OW +: OW]), 16'hFFFF);
        @(negedge clk);
        chk("R6 16x16 no wrap", int'(best_sad[40*OW +: OW]), 16'hFFF0);
        chk("R10 mv after three edges", int'(best_mv[40*MW +: MW]), 16'h4242);
        chk("R9 done on last", int'(search_done), 1);
        chk("R8 start loads even when equal", int'(best_sad[0 +: OW]), 12'hFFF);
        chk("R10 held before", hold, 16'hFFFF);

        // R7: exact tie keeps the earlier vector; a smaller block-4 SAD wins.
        put(1, 1, 0, 500, 0, 16'h0011);
        put(1, 0, 0, 500, 0, 16'h0022);
        put(1, 0, 1, 500, 1, 16'h0033);
        repeat (3) @(negedge clk);
        chk("R7 tie keeps first mv", int'(best_mv[0 +: MW]), 16'h0011);
        chk("R7 tie keeps 16x16 mv", int'(best_mv[40*MW +: MW]), 16'h0011);
        chk("R7 smaller replaces", int'(best_sad[4*OW +: OW]), 496);
        chk("R7 smaller mv", int'(best_mv[4*MW +: MW]), 16'h0033);
        check_slots("R7 tie");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule